// File: doc/BRIEF.md
# Read Data Capture Delay Unit

This block sits in the read path of a controller for an 8-bit double-data-rate memory bus whose clock the controller itself drives. When a read burst begins, the controller pulses a start strobe at the moment it begins toggling the bus clock. The unit then waits a programmed number of system clocks, samples one data byte per sampling slot, and passes each byte out with a one-cycle valid strobe until the requested byte count is reached.

The wait is set by a delay code held separately for every memory bank, so a flash device and a RAM device on the same bus can be tuned apart. The upper bits of the code give the whole-clock wait. The lowest bit switches an extra input flop into the data path, which gives a half step of delay at the pads. A built-in lookup turns the system clock rate and the rate mode into a suggested code, and software can load that suggestion into a bank's code. The bus clock output register choice is captured when a burst is accepted and held for the whole burst.

Top module: `rd_capture_delay`

## Requirements
- R1: After reset, data_o, valid_o and ck_reg_o are 0 and every bank's delay code equals the suggested half-rate code for RST_MHZ (9 for the default of 200).
- R2: dflt_code_o starts from 11 when full_rate_i is 0 and from 9 when it is 1, and drops by one for each of the breakpoints 270, 225, 180, 120 and 88 that freq_mhz_i lies strictly below.
- R3: While no burst is active, a cycle with cfg_we_i high stores into bank cfg_bank_i either cfg_code_i or, when cfg_dflt_i is 1, dflt_code_o; a start accepted in that same cycle still uses the code held before it.
- R4: A start is accepted when the unit is idle and byte_cnt_i is not 0. Calling the accepting edge E0, with W = code[CODE_W-1:1] and S = 1 for full rate or 2 for half rate (full_rate_i sampled at E0), byte k (k from 0) is sampled from dq_i at edge E0 + W + 1 + k*S.
- R5: With code bit 0 clear, byte k is on data_o with valid_o high in the cycle after its sampling edge; with bit 0 set, the same byte value appears one cycle later, through the extra input flop.
- R6: Exactly byte_cnt_i bytes are delivered per burst and valid_o is low otherwise; in half-rate mode valid_o is never high in two consecutive cycles.
- R7: A start while a burst is active, and a start with byte_cnt_i equal to 0, are ignored.
- R8: A code write during an active burst is held per bank and applied at the edge of the burst's last sampling; a later write to the same bank during that burst replaces the held one.
- R9: ck_reg_o takes ck_reg_i at each accepted start and does not change otherwise.
- R10: Against a source that presents byte j during clocks L + j*S after E0, a whole-clock wait W equal to L recovers the bytes exactly, while W = L + 1 in full-rate mode returns each byte one position later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse when the bus clock starts for a read burst |
| bank_i | input | BANK_W | Bank whose code the burst uses |
| byte_cnt_i | input | CNT_W | Bytes to capture in the burst |
| full_rate_i | input | 1 | 1: full system rate reads, 0: half rate; also feeds the lookup |
| ck_reg_i | input | 1 | Requested bus clock output register setting |
| cfg_we_i | input | 1 | Delay code write strobe |
| cfg_bank_i | input | BANK_W | Bank to write |
| cfg_code_i | input | CODE_W | Code value to write |
| cfg_dflt_i | input | 1 | Write the suggested code instead of cfg_code_i |
| freq_mhz_i | input | FREQ_W | System clock rate in MHz |
| dq_i | input | DQ_W | Raw data pins |
| data_o | output | DQ_W | Captured byte |
| valid_o | output | 1 | data_o holds a new byte this cycle |
| ck_reg_o | output | 1 | Bus clock register setting held for the burst |
| dflt_code_o | output | CODE_W | Suggested code for freq_mhz_i and full_rate_i |

## Verification
Each burst result is due at a known cycle: byte k of a burst accepted at E0 appears in the cycle after edge E0 + W + 1 + k*S + code[0], and the bench stamps every valid_o with the number of edges since E0, comparing that stamp and the byte against a source model that presents pattern bytes after a chosen latency. The lookup is combinational, so dflt_code_o is checked one time step after freq_mhz_i changes, and code writes are checked by the timing of the next burst on that bank. All sampling of outputs and all driving of inputs happen on the falling edge, away from the edge at which the design registers.

// File: rtl/rd_capture_pkg.sv
`timescale 1ns/1ps
package rd_capture_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAP} seq_st_e;

  localparam int NUM_BP    = 5;
  localparam int BP_MHZ [NUM_BP] = '{270, 225, 180, 120, 88};
  localparam int HALF_BASE = 11;
  localparam int FULL_BASE = 9;

  function automatic int dflt_lookup(int mhz, logic full);
    int c;
    c = full ? FULL_BASE : HALF_BASE;
    for (int i = 0; i < NUM_BP; i++) begin
      if (mhz < BP_MHZ[i]) c = c - 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rd_capture_codes.sv
`timescale 1ns/1ps
module rd_capture_codes
  import rd_capture_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int CODE_W  = 5,
  parameter int FREQ_W  = 9,
  parameter int RST_MHZ = 200,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              cfg_dflt_i,
  input  logic [FREQ_W-1:0] freq_mhz_i,
  input  logic              full_rate_i,
  input  logic              busy_i,
  input  logic              end_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [CODE_W-1:0] rd_code_o,
  output logic [CODE_W-1:0] dflt_code_o
);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(dflt_lookup(RST_MHZ, 1'b0));

  logic [CODE_W-1:0] code_q [NBANK];
  logic [CODE_W-1:0] pend_c [NBANK];
  logic [NBANK-1:0]  pend_v;
  logic [CODE_W-1:0] wdata;

  assign dflt_code_o = CODE_W'(dflt_lookup(int'(freq_mhz_i), full_rate_i));
  assign wdata       = cfg_dflt_i ? dflt_code_o : cfg_code_i;
  assign rd_code_o   = code_q[rd_bank_i];

  always_comb begin
    AST_DFLT_RANGE: assert (dflt_code_o <= (full_rate_i ? CODE_W'(9) : CODE_W'(11)) &&
                            dflt_code_o >= (full_rate_i ? CODE_W'(4) : CODE_W'(6))); // R2
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = cfg_we_i && (cfg_bank_i == BANK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[g] <= RST_CODE;
        pend_c[g] <= '0;
        pend_v[g] <= 1'b0;
      end else if (!busy_i) begin
        if (hit) code_q[g] <= wdata;
      end else if (end_i) begin
        // burst ends at this edge: release held write, fresh write wins
        if (hit)            code_q[g] <= wdata;
        else if (pend_v[g]) code_q[g] <= pend_c[g];
        pend_v[g] <= 1'b0;
      end else if (hit) begin
        pend_v[g] <= 1'b1;
        pend_c[g] <= wdata;
      end
    end

    AST_NO_PEND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i |-> !pend_v[g]); // R8
    AST_CODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !end_i) |=> $stable(code_q[g])); // R8
  end
endmodule

// File: rtl/rd_capture_seq.sv
`timescale 1ns/1ps
module rd_capture_seq
  import rd_capture_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 6,
  localparam int WAIT_W = CODE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              full_rate_i,
  input  logic              ck_reg_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic              end_o,
  output logic              cap_o,
  output logic              reg_sel_o,
  output logic              ck_reg_o
);
  seq_st_e           st_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [CNT_W-1:0]  left_q;
  logic              ph_q, full_q, reg_q, ck_q;
  logic [WAIT_W-1:0] wfield;
  logic              accept;

  assign wfield    = code_i[CODE_W-1:1];
  assign accept    = start_i && (st_q == ST_IDLE) && (byte_cnt_i != '0);
  assign busy_o    = (st_q != ST_IDLE);
  assign cap_o     = (st_q == ST_CAP) && !ph_q;
  assign end_o     = cap_o && (left_q == CNT_W'(1));
  assign reg_sel_o = reg_q;
  assign ck_reg_o  = ck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      left_q <= '0;
      ph_q   <= 1'b0;
      full_q <= 1'b0;
      reg_q  <= 1'b0;
      ck_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          full_q <= full_rate_i;
          reg_q  <= code_i[0];
          left_q <= byte_cnt_i;
          ph_q   <= 1'b0;
          ck_q   <= ck_reg_i;
          if (wfield == '0) st_q <= ST_CAP;
          else begin
            st_q   <= ST_WAIT;
            wcnt_q <= wfield - WAIT_W'(1);
          end
        end
        ST_WAIT: begin
          if (wcnt_q == '0) st_q <= ST_CAP;
          else              wcnt_q <= wcnt_q - WAIT_W'(1);
        end
        ST_CAP: begin
          ph_q <= full_q ? 1'b0 : ~ph_q;
          if (cap_o) begin
            left_q <= left_q - CNT_W'(1);
            if (end_o) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_FIRST_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wfield != '0) |=> !cap_o); // R4
  AST_HALF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !full_q) |=> !cap_o); // R6
  AST_NO_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> left_q != '0); // R6
  AST_CKREG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ck_reg_o)); // R9
endmodule

// File: rtl/rd_capture_tap.sv
`timescale 1ns/1ps
module rd_capture_tap #(
  parameter int DQ_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            cap_i,
  input  logic            reg_sel_i,
  output logic [DQ_W-1:0] data_o,
  output logic            valid_o
);
  logic [DQ_W-1:0] dq_q;
  logic            cap_d, fire;

  // registered path: sample lands in dq_q, output one clock later
  assign fire = reg_sel_i ? cap_d : cap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q    <= '0;
      cap_d   <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      dq_q    <= dq_i;
      cap_d   <= cap_i;
      valid_o <= fire;
      if (fire) data_o <= reg_sel_i ? dq_q : dq_i;
    end
  end

  AST_VALID_FROM_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(cap_i) || $past(cap_i, 2))); // R5
endmodule

// File: rtl/rd_capture_delay.sv
`timescale 1ns/1ps
module rd_capture_delay #(
  parameter int NBANK   = 4,
  parameter int CODE_W  = 5,
  parameter int CNT_W   = 6,
  parameter int FREQ_W  = 9,
  parameter int DQ_W    = 8,
  parameter int RST_MHZ = 200,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              full_rate_i,
  input  logic              ck_reg_i,
  input  logic              cfg_we_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              cfg_dflt_i,
  input  logic [FREQ_W-1:0] freq_mhz_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   data_o,
  output logic              valid_o,
  output logic              ck_reg_o,
  output logic [CODE_W-1:0] dflt_code_o
);
  logic [CODE_W-1:0] act_code;
  logic busy, xfer_end, cap, reg_sel;

  rd_capture_codes #(
    .NBANK(NBANK), .CODE_W(CODE_W), .FREQ_W(FREQ_W), .RST_MHZ(RST_MHZ)
  ) u_codes (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_bank_i, .cfg_code_i, .cfg_dflt_i,
    .freq_mhz_i, .full_rate_i,
    .busy_i(busy), .end_i(xfer_end), .rd_bank_i(bank_i),
    .rd_code_o(act_code), .dflt_code_o
  );

  rd_capture_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .byte_cnt_i, .full_rate_i, .ck_reg_i,
    .code_i(act_code), .busy_o(busy), .end_o(xfer_end), .cap_o(cap),
    .reg_sel_o(reg_sel), .ck_reg_o
  );

  rd_capture_tap #(.DQ_W(DQ_W)) u_tap (
    .clk_i, .rst_ni, .dq_i, .cap_i(cap), .reg_sel_i(reg_sel),
    .data_o, .valid_o
  );
endmodule

// File: tb/rd_capture_delay_bench.sv
`timescale 1ns/1ps
module rd_capture_delay_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] bank_i = '0;
  logic [5:0] byte_cnt_i = '0;
  logic       full_rate_i = 1'b0;
  logic       ck_reg_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_bank_i = '0;
  logic [4:0] cfg_code_i = '0;
  logic       cfg_dflt_i = 1'b0;
  logic [8:0] freq_mhz_i = 9'd200;
  logic [7:0] dq_i = '0;
  logic [7:0] data_o;
  logic       valid_o, ck_reg_o;
  logic [4:0] dflt_code_o;

  rd_capture_delay u_rd_capture_delay (
    .clk_i(clk), .rst_ni, .start_i, .bank_i, .byte_cnt_i, .full_rate_i,
    .ck_reg_i, .cfg_we_i, .cfg_bank_i, .cfg_code_i, .cfg_dflt_i,
    .freq_mhz_i, .dq_i, .data_o, .valid_o, .ck_reg_o, .dflt_code_o
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int t_rel = 0;
  bit arm = 0;
  int mdl_lat = 0, mdl_s = 1;
  logic [7:0] pat [64];
  logic [7:0] rec_d [64];
  int rec_t [64];
  int rec_n = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mdl(int t);
    if (t < mdl_lat) return 8'h5A;
    return pat[((t - mdl_lat) / mdl_s) & 63];
  endfunction

  function automatic int exp_dflt(int f, bit full);
    int b = full ? 9 : 11;
    if (f >= 270) return b;
    else if (f >= 225) return b - 1;
    else if (f >= 180) return b - 2;
    else if (f >= 120) return b - 3;
    else if (f >= 88)  return b - 4;
    return b - 5;
  endfunction

  // edges since accepted start
  always @(posedge clk) begin
    if (arm && start_i) t_rel = 0;
    else t_rel = t_rel + 1;
  end

  always @(negedge clk) dq_i = mdl(t_rel);

  always @(negedge clk) begin
    if (valid_o && rec_n < 64) begin
      rec_d[rec_n] = data_o;
      rec_t[rec_n] = t_rel;
      rec_n++;
    end
  end

  task automatic cfg_write(input int bank, input int code, input bit dflt);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_bank_i = 2'(bank); cfg_code_i = 5'(code); cfg_dflt_i = dflt;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_dflt_i = 1'b0;
  endtask

  task automatic xfer(input int bank, input int code, input int cnt, input bit full,
                      input int lat, input string req);
    int w, r, s;
    w = code >> 1; r = code & 1; s = full ? 1 : 2;
    mdl_lat = lat; mdl_s = s;
    for (int i = 0; i < 64; i++) pat[i] = 8'($urandom);
    rec_n = 0;
    @(negedge clk);
    start_i = 1'b1; bank_i = 2'(bank); byte_cnt_i = 6'(cnt); full_rate_i = full; arm = 1;
    @(negedge clk);
    start_i = 1'b0; arm = 0;
    repeat (w + cnt * 2 + 6) @(negedge clk);
    chk(rec_n == cnt, req, "byte count", rec_n, cnt);
    for (int k = 0; k < cnt && k < rec_n; k++) begin
      chk(rec_t[k] == w + 1 + k * s + r, req, $sformatf("byte %0d cycle", k), rec_t[k], w + 1 + k * s + r);
      chk(rec_d[k] == mdl(w + k * s), req, $sformatf("byte %0d data", k), rec_d[k], mdl(w + k * s));
    end
  endtask

  initial begin
    int fl [12] = '{50, 87, 88, 119, 120, 179, 180, 224, 225, 269, 270, 305};
    repeat (3) @(negedge clk);
    #1;
    chk(data_o == 0, "R1", "data_o reset", data_o, 0);
    chk(valid_o == 0, "R1", "valid_o reset", valid_o, 0);
    chk(ck_reg_o == 0, "R1", "ck_reg_o reset", ck_reg_o, 0);
    chk(dflt_code_o == 9, "R2", "dflt 200 half", dflt_code_o, 9);
    @(negedge clk); rst_ni = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk); freq_mhz_i = 9'(fl[i]); full_rate_i = m[0]; #1;
        chk(dflt_code_o == 5'(exp_dflt(fl[i], m[0])), "R2",
            $sformatf("dflt f=%0d full=%0d", fl[i], m), dflt_code_o, exp_dflt(fl[i], m[0]));
      end
    end

    xfer(0, 9, 8, 1, 4, "R1");
    xfer(2, 9, 5, 0, 4, "R1");
    cfg_write(1, 6, 0);
    xfer(1, 6, 6, 1, 3, "R5");
    cfg_write(1, 7, 0);
    xfer(1, 7, 6, 1, 3, "R5");
    cfg_write(2, 8, 0);
    xfer(2, 8, 6, 1, 3, "R10");
    chk(rec_d[0] == pat[1], "R10", "shifted byte 0", rec_d[0], pat[1]);
    chk(rec_d[3] == pat[4], "R10", "shifted byte 3", rec_d[3], pat[4]);
    cfg_write(3, 0, 0);
    xfer(3, 0, 4, 1, 0, "R4");
    cfg_write(3, 1, 0);
    xfer(3, 1, 4, 1, 0, "R4");
    cfg_write(3, 10, 0);
    xfer(3, 10, 7, 0, 5, "R6");

    fork
      cfg_write(0, 4, 0);
      xfer(0, 9, 5, 1, 4, "R3");
    join
    xfer(0, 4, 5, 1, 2, "R3");

    fork
      xfer(1, 7, 10, 0, 3, "R8");
      begin repeat (4) @(negedge clk); cfg_write(1, 12, 0); end
    join
    xfer(1, 12, 5, 1, 6, "R8");
    fork
      xfer(1, 12, 10, 0, 6, "R8");
      begin repeat (3) @(negedge clk); cfg_write(1, 14, 0); cfg_write(1, 5, 0); end
    join
    xfer(1, 5, 5, 1, 2, "R8");

    ck_reg_i = 1'b1;
    fork
      xfer(2, 8, 10, 0, 4, "R9");
      begin
        repeat (3) @(negedge clk);
        chk(ck_reg_o == 1, "R9", "ck_reg latched", ck_reg_o, 1);
        ck_reg_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(ck_reg_o == 1, "R9", "ck_reg held", ck_reg_o, 1);
      end
    join
    chk(ck_reg_o == 1, "R9", "ck_reg idle hold", ck_reg_o, 1);
    xfer(2, 8, 3, 1, 4, "R9");
    chk(ck_reg_o == 0, "R9", "ck_reg next burst", ck_reg_o, 0);

    fork
      xfer(2, 8, 8, 1, 4, "R7");
      begin repeat (3) @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
    join
    rec_n = 0;
    @(negedge clk); start_i = 1'b1; byte_cnt_i = '0;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(rec_n == 0, "R7", "zero count ignored", rec_n, 0);

    freq_mhz_i = 9'd100; full_rate_i = 1'b1;
    cfg_write(3, 0, 1);
    xfer(3, 5, 6, 1, 2, "R2");

    for (int it = 0; it < 24; it++) begin
      int b, c, n;
      bit f;
      b = $urandom % 4; c = 2 + ($urandom % 20); n = 1 + ($urandom % 16); f = 1'($urandom);
      cfg_write(b, c, 0);
      xfer(b, c, n, f, c >> 1, "R4");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R4 act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule